// File: doc/BRIEF.md
# Programmable-Action Watchdog Timer

This block is a memory-mapped watchdog. Software loads a tick count into a timer register over a 32-bit register bus. A down-counter then runs from that count on a separate watchdog clock. When the count reaches zero, the block carries out the expiry response that software selected. The choices are no response, an interrupt level, a non-maskable interrupt level, or a fixed-length request for a whole-chip reset.

Software keeps the system alive by rewriting the timer register before the count runs out. A sticky flag records that the most recent reset came from the watchdog. Only a power-on reset clears that flag, so it survives the chip reset the watchdog itself requests.

The load value crosses from the bus clock into the watchdog clock through a toggle request/acknowledge handshake. The live count comes back the other way through a second handshake that runs continuously. The reset generator, the interrupt controller and the clock source lie outside the block, which only drives request lines.

Top module: `wdog_timer`

## Requirements
- R1: After power-on reset, the control register reads 0x00000000, the timer register reads 0 and all three request outputs are low.
- R2: Writing offset 0x0 stores bits [1:0] as the action code, and the stored code reads back on bits [1:0] on the next access. Bits [30:2] read as 0. Bit 31 is read-only. Writes to any offset other than 0x0 and 0x4 change nothing, and reads of those offsets return 0.
- R3: Writing offset 0x4 loads the counter with the full 32-bit value after a short handshake delay. While the action code is 0 the count holds, and reads of offset 0x4 return the loaded value.
- R4: While the action code is non-zero, the count falls by exactly one per watchdog clock. The expiry response appears about L watchdog clocks after a count of L starts running.
- R5: Action code 1 raises `wd_irq` as a level on expiry. The level stays high until the timer is rewritten or the action code returns to 0.
- R6: Action code 2 raises `wd_nmi` as a level on expiry, with the same hold and clear rules as R5.
- R7: Action code 3 produces exactly one pulse on `chip_rst_req`, lasting RST_LEN watchdog clocks, for each expiry.
- R8: Rewriting offset 0x4 before the count runs out restarts the countdown, and no expiry response occurs.
- R9: With action code 0, no request output is asserted and the count does not change.
- R10: Bit 31 of the control register reads 1 once a chip-reset request has been issued. It stays 1 through bus and watchdog chip resets and is cleared only by `por_rst`.
- R11: After expiry the count stays at 0 and does not wrap.
- R12: The all-ones load value 0xFFFFFFFF is accepted and reads back unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Register bus clock |
| bus_rst | input | 1 | Synchronous chip reset, bus domain |
| wd_clk | input | 1 | Watchdog tick clock |
| wd_rst | input | 1 | Synchronous chip reset, watchdog domain |
| por_rst | input | 1 | Power-on reset; resets everything, including the last-reset flag |
| reg_sel | input | 1 | Register access strobe |
| reg_wr | input | 1 | 1 = write, 0 = read |
| reg_addr | input | ADDR_W | Byte offset: 0x0 control, 0x4 timer |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid one bus cycle after the read strobe |
| wd_irq | output | 1 | Interrupt request level on expiry (action 1) |
| wd_nmi | output | 1 | Non-maskable interrupt level on expiry (action 2) |
| chip_rst_req | output | 1 | Fixed-length chip-reset request pulse (action 3) |

## Verification
Directed loads at the extremes tell apart a counter that truncates or mis-crosses wide values from a correct one: a small count, the all-ones value, and a count held while the action is disabled. Loads and action codes drawn at random from a fixed seed each run to expiry. The response window is checked on both sides, which separates the correct L-tick latency, and the right choice among the three request lines, from off-by-many and mis-decoded behaviour. A periodic keepalive run and a disable issued after expiry set restart and clear apart from plain expiry. The reset-action run, followed by a chip reset and then a power-on reset, isolates pulse width and pulse count from the persistence of the last-reset flag.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    localparam int unsigned DATA_W       = 32;
    localparam int unsigned CTRL_OFFSET  = 0;
    localparam int unsigned TIMER_OFFSET = 4;
    localparam int unsigned FLAG_BIT     = 31;

    typedef enum logic [1:0] {
        ACT_NONE    = 2'd0,
        ACT_IRQ     = 2'd1,
        ACT_NMI     = 2'd2,
        ACT_CHIPRST = 2'd3
    } wd_action_e;

    typedef struct packed {
        logic irq;
        logic nmi;
        logic chip_rst;
    } wd_req_t;

    function automatic logic [DATA_W-1:0] pack_ctrl(logic flag, wd_action_e act);
        logic [DATA_W-1:0] v;
        v = '0;
        v[FLAG_BIT] = flag;
        v[1:0]      = act;
        return v;
    endfunction

    // interrupt-type levels for a given action when the count has run out
    function automatic wd_req_t level_req(wd_action_e act, logic hit);
        wd_req_t r;
        r.irq      = hit && (act == ACT_IRQ);
        r.nmi      = hit && (act == ACT_NMI);
        r.chip_rst = 1'b0;
        return r;
    endfunction

endpackage

// File: rtl/wdog_sync.sv
module wdog_sync #(
    parameter int unsigned W      = 1,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] stg;

    always_ff @(posedge clk) begin
        if (rst) stg <= '0;
        else     stg <= {stg[STAGES-2:0], d};
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/wdog_word_cdc.sv
module wdog_word_cdc #(
    parameter int unsigned W      = 32,
    parameter int unsigned STAGES = 2
) (
    input  logic         src_clk,
    input  logic         src_rst,
    input  logic         src_push,
    input  logic [W-1:0] src_data,
    output logic         src_idle,
    input  logic         dst_clk,
    input  logic         dst_rst,
    output logic         dst_valid,
    output logic [W-1:0] dst_data
);
    // source side
    logic         req_tgl, pend, ack_s, in_flight;
    logic [W-1:0] held, launch;
    // destination side
    logic         ack_tgl, req_s, req_d, edge_seen;

    wdog_sync #(.W(1), .STAGES(STAGES)) u_ack_sync (
        .clk(src_clk), .rst(src_rst), .d(ack_tgl), .q(ack_s));

    assign in_flight = req_tgl ^ ack_s;
    assign src_idle  = !in_flight && !pend;

    always_ff @(posedge src_clk) begin
        if (src_rst) begin
            req_tgl <= 1'b0;
            pend    <= 1'b0;
            held    <= '0;
            launch  <= '0;
        end else begin
            if (!in_flight && pend) begin
                launch  <= held;
                req_tgl <= ~req_tgl;
                pend    <= 1'b0;
            end
            if (src_push) begin
                held <= src_data;
                pend <= 1'b1;
            end
        end
    end

    wdog_sync #(.W(1), .STAGES(STAGES)) u_req_sync (
        .clk(dst_clk), .rst(dst_rst), .d(req_tgl), .q(req_s));

    assign edge_seen = req_s ^ req_d;

    always_ff @(posedge dst_clk) begin
        if (dst_rst) begin
            req_d     <= 1'b0;
            ack_tgl   <= 1'b0;
            dst_valid <= 1'b0;
            dst_data  <= '0;
        end else begin
            req_d     <= req_s;
            dst_valid <= edge_seen;
            if (edge_seen) begin
                dst_data <= launch;
                ack_tgl  <= req_s;
            end
        end
    end

    // R3
    launch_stable_chk: assert property (@(posedge src_clk) disable iff (src_rst)
        in_flight |=> $stable(launch));
endmodule

// File: rtl/wdog_regs.sv
module wdog_regs
    import wdog_pkg::*;
#(
    parameter int unsigned ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sel,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              flag,
    input  logic              mir_valid,
    input  logic [DATA_W-1:0] mir_data,
    output logic [DATA_W-1:0] rdata,
    output wd_action_e        action,
    output logic              load_push,
    output logic [DATA_W-1:0] load_data
);
    localparam logic [ADDR_W-1:0] OFS_CTRL  = ADDR_W'(CTRL_OFFSET);
    localparam logic [ADDR_W-1:0] OFS_TIMER = ADDR_W'(TIMER_OFFSET);

    logic              hit_ctrl, hit_tmr;
    logic [DATA_W-1:0] mirror;

    always_comb begin
        hit_ctrl = sel && (addr == OFS_CTRL);
        hit_tmr  = sel && (addr == OFS_TIMER);
    end

    assign load_push = hit_tmr && wr;
    assign load_data = wdata;

    always_ff @(posedge clk) begin
        if (rst) begin
            action <= ACT_NONE;
            mirror <= '0;
            rdata  <= '0;
        end else begin
            if (hit_ctrl && wr) action <= wd_action_e'(wdata[1:0]);
            if (mir_valid)      mirror <= mir_data;
            if (sel && !wr) begin
                if (hit_ctrl)     rdata <= pack_ctrl(flag, action);
                else if (hit_tmr) rdata <= mirror;
                else              rdata <= '0;
            end
        end
    end

    // R2
    ctrl_write_chk: assert property (@(posedge clk) disable iff (rst)
        (sel && wr && addr == OFS_CTRL) |=> action == wd_action_e'($past(wdata[1:0])));
endmodule

// File: rtl/wdog_core.sv
module wdog_core
    import wdog_pkg::*;
#(
    parameter int unsigned CNT_W   = 32,
    parameter int unsigned RST_LEN = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             por,
    input  wd_action_e       action,
    input  logic             load_valid,
    input  logic [CNT_W-1:0] load_data,
    output logic [CNT_W-1:0] count,
    output wd_req_t          req,
    output logic             last_rst_flag
);
    localparam int unsigned LEN_W = $clog2(RST_LEN + 1);

    logic             expired, fire, fired;
    logic [LEN_W-1:0] plen;
    wd_req_t          lvl;

    always_comb begin
        expired = (count == '0) && (action != ACT_NONE);
        fire    = expired && (action == ACT_CHIPRST) && !fired && !load_valid && !req.chip_rst;
        lvl     = level_req(action, expired && !load_valid);
    end

    always_ff @(posedge clk) begin
        if (rst)                                        count <= '0;
        else if (load_valid)                            count <= load_data;
        else if (action != ACT_NONE && count != '0)     count <= count - CNT_W'(1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            req   <= '0;
            plen  <= '0;
            fired <= 1'b0;
        end else begin
            req.irq <= lvl.irq;
            req.nmi <= lvl.nmi;
            if (load_valid) fired <= 1'b0;
            else if (fire)  fired <= 1'b1;
            if (fire) begin
                req.chip_rst <= 1'b1;
                plen         <= LEN_W'(RST_LEN - 1);
            end else if (req.chip_rst) begin
                if (plen == '0) req.chip_rst <= 1'b0;
                else            plen         <= plen - LEN_W'(1);
            end
        end
    end

    // only power-on clears the record of a watchdog-requested reset
    always_ff @(posedge clk) begin
        if (por)       last_rst_flag <= 1'b0;
        else if (fire) last_rst_flag <= 1'b1;
    end

    logic [7:0] mon_len;
    always_ff @(posedge clk) begin
        if (rst)               mon_len <= '0;
        else if (req.chip_rst) mon_len <= mon_len + 8'd1;
        else                   mon_len <= '0;
    end

    // R4
    step_one_chk: assert property (@(posedge clk) disable iff (rst)
        (!load_valid && count != '0) |=> (count == $past(count)) || (count == $past(count) - CNT_W'(1)));
    // R11
    no_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (!load_valid && count == '0) |=> count == '0);
    // R5
    one_line_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({req.irq, req.nmi, req.chip_rst}));
    // R7
    pulse_len_chk: assert property (@(posedge clk) disable iff (rst)
        ($fell(req.chip_rst) && !$past(rst)) |-> mon_len == 8'(RST_LEN));
    // R7
    pulse_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(req.chip_rst) |-> $past(action) == ACT_CHIPRST);
    // R10
    flag_set_chk: assert property (@(posedge clk) disable iff (por)
        req.chip_rst |-> last_rst_flag);
    // R10
    flag_sticky_chk: assert property (@(posedge clk) disable iff (por)
        last_rst_flag |=> last_rst_flag);
endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
    import wdog_pkg::*;
#(
    parameter int unsigned ADDR_W      = 3,
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned RST_LEN     = 4
) (
    input  logic              bus_clk,
    input  logic              bus_rst,
    input  logic              wd_clk,
    input  logic              wd_rst,
    input  logic              por_rst,
    input  logic              reg_sel,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              wd_irq,
    output logic              wd_nmi,
    output logic              chip_rst_req
);
    logic              b_rst, w_rst;
    wd_action_e        action_b, action_w;
    logic [1:0]        action_w_raw;
    logic              load_push, load_idle, load_valid;
    logic [DATA_W-1:0] load_data_b, load_data_w;
    logic              mir_idle, mir_valid;
    logic [DATA_W-1:0] count_w, mir_data;
    logic              flag_w, flag_b;
    wd_req_t           req;

    assign b_rst = bus_rst | por_rst;
    assign w_rst = wd_rst  | por_rst;

    wdog_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk(bus_clk), .rst(b_rst), .sel(reg_sel), .wr(reg_wr), .addr(reg_addr),
        .wdata(reg_wdata), .flag(flag_b), .mir_valid(mir_valid), .mir_data(mir_data),
        .rdata(reg_rdata), .action(action_b), .load_push(load_push), .load_data(load_data_b));

    wdog_sync #(.W(2), .STAGES(SYNC_STAGES)) u_act_sync (
        .clk(wd_clk), .rst(w_rst), .d(action_b), .q(action_w_raw));
    assign action_w = wd_action_e'(action_w_raw);

    wdog_word_cdc #(.W(DATA_W), .STAGES(SYNC_STAGES)) u_load_cdc (
        .src_clk(bus_clk), .src_rst(b_rst), .src_push(load_push), .src_data(load_data_b),
        .src_idle(load_idle), .dst_clk(wd_clk), .dst_rst(w_rst),
        .dst_valid(load_valid), .dst_data(load_data_w));

    wdog_core #(.CNT_W(DATA_W), .RST_LEN(RST_LEN)) u_core (
        .clk(wd_clk), .rst(w_rst), .por(por_rst), .action(action_w),
        .load_valid(load_valid), .load_data(load_data_w), .count(count_w),
        .req(req), .last_rst_flag(flag_w));

    wdog_word_cdc #(.W(DATA_W), .STAGES(SYNC_STAGES)) u_mirror_cdc (
        .src_clk(wd_clk), .src_rst(w_rst), .src_push(mir_idle), .src_data(count_w),
        .src_idle(mir_idle), .dst_clk(bus_clk), .dst_rst(b_rst),
        .dst_valid(mir_valid), .dst_data(mir_data));

    wdog_sync #(.W(1), .STAGES(SYNC_STAGES)) u_flag_sync (
        .clk(bus_clk), .rst(por_rst), .d(flag_w), .q(flag_b));

    assign wd_irq       = req.irq;
    assign wd_nmi       = req.nmi;
    assign chip_rst_req = req.chip_rst;

    // R3
    load_accept_chk: assert property (@(posedge bus_clk) disable iff (b_rst)
        load_push |=> !load_idle);
endmodule

// File: tb/test_wdog_timer.sv
module test_wdog_timer;
    import wdog_pkg::*;

    localparam int unsigned RST_LEN = 4;

    logic        bus_clk = 1'b0, wd_clk = 1'b0;
    logic        bus_rst = 1'b0, wd_rst = 1'b0, por_rst = 1'b1;
    logic        reg_sel = 1'b0, reg_wr = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        wd_irq, wd_nmi, chip_rst_req;

    int n_cmp = 0, n_bad = 0;
    int pulse_edges = 0, pulse_high = 0;
    logic prev_req = 1'b0;

    wdog_timer #(.ADDR_W(3), .SYNC_STAGES(2), .RST_LEN(RST_LEN)) i_wdog_timer (
        .bus_clk(bus_clk), .bus_rst(bus_rst), .wd_clk(wd_clk), .wd_rst(wd_rst),
        .por_rst(por_rst), .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .wd_irq(wd_irq),
        .wd_nmi(wd_nmi), .chip_rst_req(chip_rst_req));

    always #5 bus_clk = ~bus_clk;
    initial begin
        #7;
        forever #20 wd_clk = ~wd_clk;
    end

    always @(negedge wd_clk) begin
        if (chip_rst_req) pulse_high++;
        if (chip_rst_req && !prev_req) pulse_edges++;
        prev_req = chip_rst_req;
    end

    function automatic logic [31:0] exp_ctrl(bit flag, logic [1:0] act);
        return {flag, 29'd0, act};
    endfunction

    function automatic logic [2:0] exp_lines(logic [1:0] act, bit ran_out);
        return {ran_out && act == 2'd1, ran_out && act == 2'd2, 1'b0};
    endfunction

    function automatic logic [2:0] lines();
        return {wd_irq, wd_nmi, chip_rst_req};
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic chk_ok(string tag, bit ok, logic [31:0] act, logic [31:0] ref_v);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=relative to %h", tag, act, ref_v);
        end
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge bus_clk);
    endtask

    task automatic bus_write(logic [2:0] a, logic [31:0] d);
        @(negedge bus_clk);
        reg_sel = 1'b1; reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge bus_clk);
        reg_sel = 1'b0; reg_wr = 1'b0;
    endtask

    task automatic bus_read(logic [2:0] a, output logic [31:0] d);
        @(negedge bus_clk);
        reg_sel = 1'b1; reg_wr = 1'b0; reg_addr = a;
        @(negedge bus_clk);
        reg_sel = 1'b0;
        d = reg_rdata;
    endtask

    task automatic chip_reset();
        bus_rst = 1'b1; wd_rst = 1'b1;
        idle(48);
        bus_rst = 1'b0; wd_rst = 1'b0;
        idle(8);
    endtask

    task automatic power_on();
        por_rst = 1'b1;
        idle(48);
        por_rst = 1'b0;
        idle(8);
    endtask

    task automatic run_expiry(int len, logic [1:0] act);
        logic [31:0] v, v2;
        string tag;
        tag = (act == 2'd1) ? "R5" : "R6";
        bus_write(3'd4, len);
        idle(40);
        bus_write(3'd0, {30'd0, act});
        idle(len * 2);
        bus_read(3'd4, v);
        chk_ok("R4 count running", v < len && v > 0, v, len);
        idle(len * 2 - 26);
        chk("R4 no response before L ticks", {29'd0, lines()}, 32'd0);
        idle(64);
        chk({tag, " response after L ticks"}, {29'd0, lines()}, {29'd0, exp_lines(act, 1'b1)});
        bus_read(3'd4, v);
        chk("R11 count stays at zero", v, 32'd0);
        idle(200);
        chk({tag, " level held"}, {29'd0, lines()}, {29'd0, exp_lines(act, 1'b1)});
        bus_write(3'd4, len);
        idle(32);
        chk({tag, " reload clears"}, {29'd0, lines()}, 32'd0);
        bus_write(3'd0, 32'd0);
        idle(32);
        chk("R9 disabled lines low", {29'd0, lines()}, 32'd0);
        bus_read(3'd4, v);
        idle(100);
        bus_read(3'd4, v2);
        chk("R9 count frozen", v2, v);
    endtask

    initial begin
        repeat (150000) @(posedge bus_clk);
        n_bad++;
        $display("FAIL watchdog all-requirements actual=hung expected=finished");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] v;
        int e0, h0;
        void'($urandom(32'd24681));
        idle(48);
        por_rst = 1'b0;
        idle(8);

        // R1 reset state
        bus_read(3'd0, v); chk("R1 ctrl after power-on", v, 32'd0);
        bus_read(3'd4, v); chk("R1 timer after power-on", v, 32'd0);
        chk("R1 lines after power-on", {29'd0, lines()}, 32'd0);

        // R2 control field, read-only bits, unmapped offsets
        bus_write(3'd4, 32'd1000);
        idle(40);
        bus_write(3'd0, 32'hFFFF_FFFE);
        bus_read(3'd0, v); chk("R2 action readback", v, exp_ctrl(1'b0, 2'd2));
        bus_write(3'd0, 32'd0);
        bus_read(3'd0, v); chk("R2 action cleared", v, exp_ctrl(1'b0, 2'd0));
        bus_write(3'd2, 32'd3);
        bus_read(3'd0, v); chk("R2 unmapped write ignored", v, 32'd0);
        bus_read(3'd2, v); chk("R2 unmapped read zero", v, 32'd0);
        chk("R2 lines quiet", {29'd0, lines()}, 32'd0);

        // R3 / R12 loads held while disabled
        bus_write(3'd4, 32'h0000_1234);
        idle(40);
        bus_read(3'd4, v); chk("R3 load visible", v, 32'h0000_1234);
        idle(100);
        bus_read(3'd4, v); chk("R3 held with action 0", v, 32'h0000_1234);
        bus_write(3'd4, 32'hFFFF_FFFF);
        idle(40);
        bus_read(3'd4, v); chk("R12 full-width load", v, 32'hFFFF_FFFF);

        // directed expiries, then random ones
        run_expiry(30, 2'd1);
        run_expiry(25, 2'd2);
        for (int i = 0; i < 5; i++) begin
            int len;
            logic [1:0] act;
            len = 20 + int'($urandom % 60);
            act = 2'd1 + 2'($urandom % 2);
            run_expiry(len, act);
        end

        // R8 keepalive
        bus_write(3'd4, 32'd60);
        idle(40);
        bus_write(3'd0, 32'd1);
        for (int k = 0; k < 6; k++) begin
            idle(120);
            bus_write(3'd4, 32'd60);
            chk("R8 no expiry under keepalive", {29'd0, lines()}, 32'd0);
        end
        idle(72 * 4);
        chk("R8 expiry after keepalive stops", {29'd0, lines()}, {29'd0, exp_lines(2'd1, 1'b1)});
        bus_write(3'd0, 32'd0);
        idle(32);

        // R7 / R10 chip-reset action and sticky flag
        e0 = pulse_edges; h0 = pulse_high;
        bus_write(3'd4, 32'd20);
        idle(40);
        bus_write(3'd0, 32'd3);
        idle(600);
        chk("R7 exactly one pulse", pulse_edges - e0, 32'd1);
        chk("R7 pulse width", pulse_high - h0, RST_LEN);
        chk("R7 no interrupt lines", {30'd0, wd_irq, wd_nmi}, 32'd0);
        bus_read(3'd0, v); chk("R10 flag set", v, exp_ctrl(1'b1, 2'd3));
        chip_reset();
        bus_read(3'd0, v); chk("R10 flag survives chip reset", v, exp_ctrl(1'b1, 2'd0));
        idle(200);
        chk("R7 no pulse after chip reset", pulse_edges - e0, 32'd1);
        power_on();
        bus_read(3'd0, v); chk("R10 power-on clears flag", v, 32'd0);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule